// File: doc/BRIEF.md
# Prescaled Eight-Bit Tick Timer with Load Stall

This block is an 8-bit up-counter. The instruction-cycle clock advances it, either directly or through a power-of-two divider. Software can load a new count value through a write strobe and data bus. Each load freezes both the counter and the divider for two instruction cycles, which models an internal synchronization delay. The load also restarts the divider from zero. A program that wants a period of N counts before rollover therefore preloads 256 − N and adds a correction for the two stalled cycles. With no divider the correction is +2, so 158 gives a 100-cycle period. With the divider on, the correction scales with the ratio.

When the count wraps from 0xFF to 0x00, a sticky overflow flag is raised. It stays high until a clear pulse removes it. If a wrap and a clear happen in the same cycle, the wrap wins. Reset is asynchronous and active low. Its release passes through a two-stage synchronizer, so the first functional rising edge is the third one after the reset pin goes high.

Top module: `tick_timer8`

## Requirements
- R1: While reset is low, and for the first two rising edges after it goes high, the count and the flag are 0. The third edge after release is the first one that can change them.
- R2: A write strobe sampled at an edge loads the data bus into the count at that edge.
- R3: The two rising edges that follow a load edge change neither the count nor the divider. With the divider bypassed, the first increment happens on the third edge after the load.
- R4: A load resets the divider phase to zero. With ratio R, the first increment after a load happens on edge 2 + R after the load edge.
- R5: With the divider bypassed (div_en = 0), the count increments on every edge once the stall ends. Preloading 158 raises the flag exactly 100 edges after the load edge.
- R6: With div_en = 1, the count increments once every R edges, where R = 2 << div_sel. div_sel = 0 gives 1:2 and div_sel = 7 gives 1:256.
- R7: An increment from 0xFF gives a count of 0x00 and sets the flag on the same edge.
- R8: The flag holds until flag_clr is sampled high. If a wrap and a clear coincide, the flag ends set.
- R9: A load during an active stall reloads the count, clears the divider and restarts the full two-edge stall.
- R10: A load at an edge where the count is 0xFF and an increment was due takes priority. The count takes the written value and the flag does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load strobe for the count |
| wr_data | input | 8 | Value to load |
| div_en | input | 1 | 1 routes increments through the divider, 0 bypasses it |
| div_sel | input | 3 | Divider ratio select, R = 2 << div_sel |
| flag_clr | input | 1 | Clears the overflow flag |
| count | output | 8 | Current count |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The hardest case to reach is the edge where three things meet: the stall has just ended, the count sits at 0xFF, and a new load or a flag clear lands on that same edge. The bench reaches it deterministically. It preloads 0xFF with the divider bypassed, waits exactly two edges, and then drives either a load or a held clear on the third edge. Divider phase restarts are forced the same way, by loading while changing the ratio. The bench then measures the edge distance to the first increment and to the next one, for ratios 1:2, 1:8, 1:32 and 1:256.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int unsigned TT_CNT_W   = 8;
  localparam int unsigned TT_SEL_W   = 3;
  localparam int unsigned TT_STALL   = 2;
  localparam int unsigned TT_RST_STG = 2;
endpackage

// File: rtl/tt_rst_sync.sv
module tt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/tt_stall.sv
module tt_stall #(
  parameter int unsigned STALL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic run
);
  localparam int unsigned SW = $clog2(STALL + 1);

  logic [SW-1:0] left_q;
  logic [SW-1:0] left_d;
  logic          left_en;

  always_comb begin
    left_en = load | (left_q != '0);
    left_d  = left_q;
    if (load)               left_d = SW'(STALL);
    else if (left_q != '0)  left_d = left_q - SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (left_en) left_q <= left_d;
  end

  assign run = (left_q == '0) & ~load;

  AST_STALL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (left_q == SW'(STALL))); // R9
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !run); // R3
endmodule

// File: rtl/tt_divider.sv
module tt_divider #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             use_div,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned PW = 1 << SEL_W;

  logic [PW-1:0] ph_q;
  logic [PW-1:0] ph_d;
  logic          ph_en;
  logic [PW:0]   span;
  logic [PW-1:0] mask;

  always_comb begin
    span  = ((PW+1)'(2) << sel) - (PW+1)'(1);
    mask  = span[PW-1:0];
    tick  = run & (~use_div | ((ph_q & mask) == mask));
    ph_en = clr | (run & use_div);
    ph_d  = clr ? '0 : ph_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ph_q <= '0;
    else if (ph_en) ph_q <= ph_d;
  end

  AST_PHASE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ph_q == '0)); // R4
  AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(ph_q)); // R3
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  input  logic         flag_clr,
  output logic [W-1:0] cnt,
  output logic         flag
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;
  logic         flag_q, flag_d, flag_en;
  logic         wrap;

  always_comb begin
    wrap    = tick & ~load & (cnt_q == '1);
    cnt_en  = load | tick;
    cnt_d   = load ? load_val : cnt_q + W'(1);
    flag_en = wrap | flag_clr;
    flag_d  = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val))); // R2
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + W'(1))); // R6
  AST_FLAG_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> (cnt_q == '0 && $past(cnt_q) == '1)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q); // R8
endmodule

// File: rtl/tick_timer8.sv
module tick_timer8
  import tt_pkg::*;
#(
  parameter int unsigned CNT_W   = TT_CNT_W,
  parameter int unsigned SEL_W   = TT_SEL_W,
  parameter int unsigned STALL   = TT_STALL,
  parameter int unsigned RST_STG = TT_RST_STG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             div_en,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  logic rst_s;
  logic run;
  logic tick;

  tt_rst_sync #(.STAGES(RST_STG)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_s)
  );

  tt_stall #(.STALL(STALL)) u_stall (
    .clk   (clk),
    .rst_n (rst_s),
    .load  (wr_en),
    .run   (run)
  );

  tt_divider #(.SEL_W(SEL_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_s),
    .clr     (wr_en),
    .run     (run),
    .use_div (div_en),
    .sel     (div_sel),
    .tick    (tick)
  );

  tt_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_s),
    .load     (wr_en),
    .load_val (wr_data),
    .tick     (tick),
    .flag_clr (flag_clr),
    .cnt      (count),
    .flag     (ovf)
  );

  AST_LOAD_BEATS_WRAP: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_en && count == '1) |=> !$rose(ovf)); // R10
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_s |-> (count == '0 && !ovf)); // R1
endmodule

// File: tb/test_tick_timer8.sv
module test_tick_timer8;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       div_en;
  logic [2:0] div_sel;
  logic       flag_clr;
  logic [7:0] count;
  logic       ovf;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int m_cnt, m_ovf, m_ph, m_stall, m_rel;

  always #4 clk = ~clk;

  tick_timer8 i_tick_timer8 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .div_en(div_en), .div_sel(div_sel), .flag_clr(flag_clr),
    .count(count), .ovf(ovf)
  );

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Behavioural reference: one step per rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ovf = 0; m_ph = 0; m_stall = 0; m_rel = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      bit inc;
      inc = 0;
      if (flag_clr) m_ovf = 0;
      if (wr_en) begin
        m_cnt = wr_data; m_ph = 0; m_stall = 2;
      end else if (m_stall > 0) begin
        m_stall--;
      end else if (!div_en) begin
        inc = 1;
      end else begin
        m_ph++;
        if (m_ph == (2 << div_sel)) begin m_ph = 0; inc = 1; end
      end
      if (inc) begin
        if (m_cnt == 255) begin m_cnt = 0; m_ovf = 1; end
        else m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n === 1'b1) begin
      chk("R6 model count", count == m_cnt[7:0], count, m_cnt);
      chk("R8 model flag", ovf == m_ovf[0], ovf, m_ovf);
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic load(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic edges_to_change(output int n);
    logic [7:0] start;
    start = count;
    n = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      n++;
      if (count != start) break;
    end
  endtask

  task automatic edges_to_flag(output int n);
    n = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      n++;
      if (ovf) break;
    end
  endtask

  task automatic pulse_clear();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic div_run(input logic [2:0] s);
    int n, r;
    r = 2 << s;
    div_en = 1'b1; div_sel = s;
    load(8'h10);
    edges_to_change(n);
    chk("R4 first step after load", n == r + 2, n, r + 2);
    edges_to_change(n);
    chk("R6 divided step period", n == r, n, r);
  endtask

  initial begin
    int n;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    div_en = 1'b0; div_sel = '0; flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 count in reset", count == 8'h00, count, 0);
    chk("R1 flag in reset", ovf == 1'b0, ovf, 0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 held two edges after release", count == 8'h00, count, 0);
    @(negedge clk);
    chk("R1 first functional edge", count == 8'h01, count, 1);
    repeat (3) @(negedge clk);

    load(8'h5A);
    chk("R2 load value", count == 8'h5A, count, 8'h5A);
    edges_to_change(n);
    chk("R3 stall then step", n == 3, n, 3);

    load(8'h20);
    @(negedge clk);
    load(8'h40);
    chk("R9 reload during stall", count == 8'h40, count, 8'h40);
    edges_to_change(n);
    chk("R9 stall restarted", n == 3, n, 3);

    pulse_clear();
    chk("R8 clear", ovf == 1'b0, ovf, 0);
    load(8'd158);
    edges_to_flag(n);
    chk("R5 preload 158 period", n == 100, n, 100);
    chk("R7 wrapped to zero", count == 8'h00, count, 0);
    repeat (5) @(negedge clk);
    chk("R8 flag holds", ovf == 1'b1, ovf, 1);
    pulse_clear();
    chk("R8 flag cleared", ovf == 1'b0, ovf, 0);

    load(8'hFF);
    flag_clr = 1'b1;
    repeat (3) @(negedge clk);
    flag_clr = 1'b0;
    chk("R8 set wins over clear", ovf == 1'b1, ovf, 1);
    chk("R7 wrap count", count == 8'h00, count, 0);

    pulse_clear();
    load(8'hFF);
    repeat (2) @(negedge clk);
    load(8'h33);
    chk("R10 load beats wrap count", count == 8'h33, count, 8'h33);
    chk("R10 load beats wrap flag", ovf == 1'b0, ovf, 0);

    div_run(3'd0);
    div_run(3'd2);
    div_run(3'd4);
    div_run(3'd7);

    div_en = 1'b0; div_sel = '0;
    load(8'h00);
    repeat (3) @(negedge clk);
    chk("R5 bypass resumes", count == 8'h01, count, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule